// File: doc/BRIEF.md
# Descriptor-Driven Transmit Sequencer

This block walks a ring of transmit descriptors kept in an on-chip descriptor RAM and moves each described frame from system memory to a byte-wide transmit stream. A descriptor takes two consecutive RAM words. The word at the even index holds control and status. The word after it holds the byte address of the frame buffer. When a descriptor is marked ready, the block latches the frame attributes, fetches the buffer one 32-bit word at a time and sends its bytes most significant first. It then waits for the transmit side to report the outcome, writes the updated status word back into the same slot and moves on to the next slot.

The transmit side receives three attributes with every frame: a minimum length (the padding target), a maximum length (the oversize limit) and a CRC-append flag. Each attribute is decided from a per-descriptor flag together with a global mode input. Completion produces a one-cycle success or error event, and also an interrupt pulse when the descriptor asks for one and at least one completion mask is set. CRC generation, retries and line signalling belong to the transmit side.

Status word layout: length in bits 31:16, ready 15, interrupt-request 14, wrap 13, pad 12, CRC 11, last 10, underrun 9, retransmit-limit 8, retry count 7:4, carrier-lost 3, collision 2, defer 1. Bit 0 is unused and is carried through unchanged.

Top module: `txdesc_engine`

## Requirements
- R1: After reset, desc_wr_en, mem_req, tx_valid, evt_txb, evt_txe and irq are low and desc_rd_addr is 0.
- R2: No memory read and no write-back happen while the slot at desc_rd_addr has its ready bit (15) clear, or while cfg_tx_en is low. With cfg_tx_en low the block returns to idle and accepts nothing.
- R3: The word written back equals the accepted status word with bits 15, 9, 8, 7:4, 3, 2 and 1 cleared. All other bits, including bit 0, keep their values.
- R4: tx_min_len equals cfg_min_len when the descriptor pad bit (12) or cfg_pad_all is set. Otherwise it equals the descriptor length.
- R5: tx_max_len equals the descriptor length when cfg_huge is set. Otherwise it equals cfg_max_len.
- R6: tx_add_crc is set when cfg_crc_all is set, or when both the CRC bit (11) and the last bit (10) are set. The CRC bit alone does not set it.
- R7: A frame of length L needs exactly ceil(L/4) memory reads at addresses pointer+4k, k ascending. A frame of length 0 needs none.
- R8: A frame of length L produces exactly L stream bytes: the bytes of each fetched word are sent from bits 31:24 downwards, and tx_last is high on the final byte only. Under backpressure, a byte and its tx_last stay unchanged until they are accepted.
- R9: In the cycle after tx_done is sampled, desc_wr_en is high for one cycle at the descriptor's own index. At the same time evt_txb is high if tx_ok was set, and evt_txe is high otherwise.
- R10: irq pulses together with the write-back only when the descriptor's interrupt-request bit (14) is set and cfg_mask_txb or cfg_mask_txe is set.
- R11: After a write-back the index advances by 2. It becomes 0 instead when the wrap bit (13) was set or when the advanced index would reach RING_WORDS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_tx_en | input | 1 | Enables descriptor processing |
| cfg_pad_all | input | 1 | Global pad mode |
| cfg_huge | input | 1 | Allow frames beyond cfg_max_len |
| cfg_crc_all | input | 1 | Global CRC append |
| cfg_min_len | input | 16 | Configured minimum frame length |
| cfg_max_len | input | 16 | Configured maximum frame length |
| cfg_mask_txb | input | 1 | Success interrupt mask |
| cfg_mask_txe | input | 1 | Error interrupt mask |
| desc_rd_addr | output | IDXW | Current descriptor index (status word) |
| desc_stat_rdata | input | 32 | RAM word at desc_rd_addr |
| desc_ptr_rdata | input | 32 | RAM word at desc_rd_addr+1 |
| desc_wr_en | output | 1 | Status write-back strobe |
| desc_wr_addr | output | IDXW | Write-back index |
| desc_wr_data | output | 32 | Write-back status word |
| mem_req | output | 1 | Memory word read request, held until served |
| mem_addr | output | AW | Byte address of requested word |
| mem_rvalid | input | 1 | Read data valid; completes the request |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of frame |
| tx_ready | input | 1 | Stream byte accepted |
| tx_min_len | output | 16 | Frame minimum length attribute |
| tx_max_len | output | 16 | Frame maximum length attribute |
| tx_add_crc | output | 1 | Frame CRC-append attribute |
| tx_done | input | 1 | Transmit side completion pulse |
| tx_ok | input | 1 | Completion outcome, valid with tx_done |
| evt_txb | output | 1 | Success event pulse |
| evt_txe | output | 1 | Error event pulse |
| irq | output | 1 | Interrupt pulse |

## Verification
The write-back strobe, the success or error event, the interrupt pulse and the advanced index all come out of registers, one clock after the edge at which tx_done is seen. The bench raises tx_done on a falling edge and examines all of them on the next falling edge, which is exactly one cycle later. Frame attributes are registered when the descriptor is accepted and stay unchanged until the next one, so they are read after completion. Stream bytes and memory reads are counted by a monitor that samples the handshake between edges, so their checks do not depend on how many cycles the fetch and drain take.

// File: rtl/txdesc_pkg.sv
package txdesc_pkg;
  localparam int LEN_LSB   = 16;
  localparam int LEN_W     = 16;
  localparam int B_READY   = 15;
  localparam int B_IRQ     = 14;
  localparam int B_WRAP    = 13;
  localparam int B_PAD     = 12;
  localparam int B_CRC     = 11;
  localparam int B_LAST    = 10;
  localparam int B_UNDER   = 9;
  localparam int B_RETLIM  = 8;
  localparam int RETRY_LSB = 4;
  localparam int RETRY_W   = 4;
  localparam int B_NOCARR  = 3;
  localparam int B_COLL    = 2;
  localparam int B_DEFER   = 1;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_READ, ST_XMIT} txd_state_e;

  // status word with all per-attempt outcome fields reset
  function automatic logic [31:0] scrub_status(input logic [31:0] s);
    logic [31:0] r;
    r = s;
    r[B_DEFER]  = 1'b0;
    r[B_COLL]   = 1'b0;
    r[B_RETLIM] = 1'b0;
    r[B_UNDER]  = 1'b0;
    r[B_NOCARR] = 1'b0;
    r[RETRY_LSB +: RETRY_W] = '0;
    return r;
  endfunction

  function automatic logic [LEN_W-1:0] pick_min(input logic pad_desc, input logic pad_all,
                                                input logic [LEN_W-1:0] cfg_min,
                                                input logic [LEN_W-1:0] len);
    return (pad_desc || pad_all) ? cfg_min : len;
  endfunction

  function automatic logic [LEN_W-1:0] pick_max(input logic huge,
                                                input logic [LEN_W-1:0] cfg_max,
                                                input logic [LEN_W-1:0] len);
    return huge ? len : cfg_max;
  endfunction

  function automatic logic want_crc(input logic crc_all, input logic crc_flag, input logic last_flag);
    return crc_all || (crc_flag && last_flag);
  endfunction
endpackage

// File: rtl/txdesc_word_ser.sv
module txdesc_word_ser (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [31:0] word,
  input  logic [2:0] nbytes,
  input  logic       last_word,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       tx_last,
  output logic       empty
);
  logic [31:0] word_q;
  logic [1:0]  pos_q;
  logic [2:0]  rem_q;
  logic        last_q;
  logic [7:0]  lane [4];

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign lane[g] = word_q[31-8*g -: 8];
  end

  assign tx_valid = (rem_q != 3'd0);
  assign tx_data  = lane[pos_q];
  assign tx_last  = last_q && (rem_q == 3'd1);
  assign empty    = (rem_q == 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      pos_q  <= '0;
      rem_q  <= '0;
      last_q <= 1'b0;
    end else if (load) begin
      word_q <= word;
      pos_q  <= '0;
      rem_q  <= nbytes;
      last_q <= last_word;
    end else if (tx_valid && tx_ready) begin
      pos_q <= pos_q + 2'd1;
      rem_q <= rem_q - 3'd1;
    end
  end
endmodule

// File: rtl/txdesc_ctrl.sv
module txdesc_ctrl
  import txdesc_pkg::*;
#(
  parameter int RING_WORDS = 16,
  parameter int AW = 32,
  localparam int IDXW = $clog2(RING_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_tx_en,
  input  logic             cfg_pad_all,
  input  logic             cfg_huge,
  input  logic             cfg_crc_all,
  input  logic [LEN_W-1:0] cfg_min_len,
  input  logic [LEN_W-1:0] cfg_max_len,
  input  logic             cfg_mask_txb,
  input  logic             cfg_mask_txe,
  output logic [IDXW-1:0]  desc_rd_addr,
  input  logic [31:0]      desc_stat_rdata,
  input  logic [31:0]      desc_ptr_rdata,
  output logic             desc_wr_en,
  output logic [IDXW-1:0]  desc_wr_addr,
  output logic [31:0]      desc_wr_data,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  input  logic             mem_rvalid,
  input  logic [31:0]      mem_rdata,
  output logic             ser_load,
  output logic [31:0]      ser_word,
  output logic [2:0]       ser_nbytes,
  output logic             ser_last,
  input  logic             ser_empty,
  input  logic             tx_done,
  input  logic             tx_ok,
  output logic [LEN_W-1:0] tx_min_len,
  output logic [LEN_W-1:0] tx_max_len,
  output logic             tx_add_crc,
  output logic             evt_txb,
  output logic             evt_txe,
  output logic             irq
);
  localparam int CW = LEN_W + 1;

  txd_state_e       state_q;
  logic [IDXW-1:0]  idx_q;
  logic [31:0]      stat_q;
  logic [AW-1:0]    ptr_q;
  logic [LEN_W-1:0] len_q;
  logic [CW-1:0]    cnt_q;
  logic             fetch_q;

  function automatic logic [IDXW-1:0] next_idx(input logic [IDXW-1:0] cur, input logic wrap);
    logic [IDXW:0] nx;
    nx = {1'b0, cur} + (IDXW+1)'(2);
    if (wrap || nx >= (IDXW+1)'(RING_WORDS)) return '0;
    return nx[IDXW-1:0];
  endfunction

  // named internal events
  wire [LEN_W-1:0] desc_len  = desc_stat_rdata[LEN_LSB +: LEN_W];
  wire             accept    = (state_q == ST_WAIT) && cfg_tx_en &&
                               desc_stat_rdata[B_READY] && !desc_wr_en;
  wire [CW-1:0]    left      = {1'b0, len_q} - cnt_q;
  wire             word_in   = (state_q == ST_READ) && fetch_q && mem_rvalid;
  wire             drained   = (state_q == ST_READ) && !fetch_q && ser_empty;
  wire             all_read  = (cnt_q >= {1'b0, len_q});
  wire             finish    = (state_q == ST_XMIT) && tx_done;

  assign desc_rd_addr = idx_q;
  assign mem_req      = (state_q == ST_READ) && fetch_q;
  assign mem_addr     = ptr_q + AW'(cnt_q);
  assign ser_load     = word_in;
  assign ser_word     = mem_rdata;
  assign ser_nbytes   = (left >= CW'(4)) ? 3'd4 : left[2:0];
  assign ser_last     = (left <= CW'(4));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      idx_q        <= '0;
      stat_q       <= '0;
      ptr_q        <= '0;
      len_q        <= '0;
      cnt_q        <= '0;
      fetch_q      <= 1'b0;
      tx_min_len   <= '0;
      tx_max_len   <= '0;
      tx_add_crc   <= 1'b0;
      desc_wr_en   <= 1'b0;
      desc_wr_addr <= '0;
      desc_wr_data <= '0;
      evt_txb      <= 1'b0;
      evt_txe      <= 1'b0;
      irq          <= 1'b0;
    end else begin
      desc_wr_en <= 1'b0;
      evt_txb    <= 1'b0;
      evt_txe    <= 1'b0;
      irq        <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (cfg_tx_en) state_q <= ST_WAIT;
        ST_WAIT: begin
          if (!cfg_tx_en) begin
            state_q <= ST_IDLE;
          end else if (accept) begin
            stat_q     <= scrub_status(desc_stat_rdata);
            ptr_q      <= AW'(desc_ptr_rdata);
            len_q      <= desc_len;
            cnt_q      <= '0;
            fetch_q    <= (desc_len != '0);
            tx_min_len <= pick_min(desc_stat_rdata[B_PAD], cfg_pad_all, cfg_min_len, desc_len);
            tx_max_len <= pick_max(cfg_huge, cfg_max_len, desc_len);
            tx_add_crc <= want_crc(cfg_crc_all, desc_stat_rdata[B_CRC], desc_stat_rdata[B_LAST]);
            state_q    <= ST_READ;
          end
        end
        ST_READ: begin
          if (word_in) begin
            cnt_q   <= cnt_q + CW'(4);
            fetch_q <= 1'b0;
          end else if (drained) begin
            if (all_read) state_q <= ST_XMIT;
            else fetch_q <= 1'b1;
          end
        end
        ST_XMIT: begin
          if (finish) begin
            desc_wr_en   <= 1'b1;
            desc_wr_addr <= idx_q;
            desc_wr_data <= stat_q & ~((32'd1 << B_READY) | (32'd1 << B_COLL));
            evt_txb      <= tx_ok;
            evt_txe      <= !tx_ok;
            irq          <= stat_q[B_IRQ] && (cfg_mask_txb || cfg_mask_txe);
            idx_q        <= next_idx(idx_q, stat_q[B_WRAP]);
            state_q      <= ST_WAIT;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txdesc_engine.sv
module txdesc_engine #(
  parameter int RING_WORDS = 16,
  parameter int AW = 32,
  localparam int IDXW = $clog2(RING_WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_tx_en,
  input  logic            cfg_pad_all,
  input  logic            cfg_huge,
  input  logic            cfg_crc_all,
  input  logic [15:0]     cfg_min_len,
  input  logic [15:0]     cfg_max_len,
  input  logic            cfg_mask_txb,
  input  logic            cfg_mask_txe,
  output logic [IDXW-1:0] desc_rd_addr,
  input  logic [31:0]     desc_stat_rdata,
  input  logic [31:0]     desc_ptr_rdata,
  output logic            desc_wr_en,
  output logic [IDXW-1:0] desc_wr_addr,
  output logic [31:0]     desc_wr_data,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  input  logic            mem_rvalid,
  input  logic [31:0]     mem_rdata,
  output logic            tx_valid,
  output logic [7:0]      tx_data,
  output logic            tx_last,
  input  logic            tx_ready,
  output logic [15:0]     tx_min_len,
  output logic [15:0]     tx_max_len,
  output logic            tx_add_crc,
  input  logic            tx_done,
  input  logic            tx_ok,
  output logic            evt_txb,
  output logic            evt_txe,
  output logic            irq
);
  logic        ser_load;
  logic [31:0] ser_word;
  logic [2:0]  ser_nbytes;
  logic        ser_last;
  logic        ser_empty;

  txdesc_ctrl #(.RING_WORDS(RING_WORDS), .AW(AW)) u_ctrl (
    .clk, .rst_n, .cfg_tx_en, .cfg_pad_all, .cfg_huge, .cfg_crc_all,
    .cfg_min_len, .cfg_max_len, .cfg_mask_txb, .cfg_mask_txe,
    .desc_rd_addr, .desc_stat_rdata, .desc_ptr_rdata,
    .desc_wr_en, .desc_wr_addr, .desc_wr_data,
    .mem_req, .mem_addr, .mem_rvalid, .mem_rdata,
    .ser_load, .ser_word, .ser_nbytes, .ser_last, .ser_empty,
    .tx_done, .tx_ok, .tx_min_len, .tx_max_len, .tx_add_crc,
    .evt_txb, .evt_txe, .irq
  );

  txdesc_word_ser u_ser (
    .clk, .rst_n,
    .load(ser_load), .word(ser_word), .nbytes(ser_nbytes), .last_word(ser_last),
    .tx_ready, .tx_valid, .tx_data, .tx_last, .empty(ser_empty)
  );
endmodule

// File: rtl/txdesc_engine_chk.sv
module txdesc_engine_chk #(
  parameter int RING_WORDS = 16,
  localparam int IDXW = $clog2(RING_WORDS)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_mask_txb,
  input logic            cfg_mask_txe,
  input logic [IDXW-1:0] desc_rd_addr,
  input logic            desc_wr_en,
  input logic [IDXW-1:0] desc_wr_addr,
  input logic [31:0]     desc_wr_data,
  input logic            mem_req,
  input logic [31:0]     mem_addr,
  input logic            mem_rvalid,
  input logic            tx_valid,
  input logic [7:0]      tx_data,
  input logic            tx_last,
  input logic            tx_ready,
  input logic            evt_txb,
  input logic            evt_txe,
  input logic            irq
);
  assert_wb_ready_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    desc_wr_en |-> (!desc_wr_data[15] && !desc_wr_data[2] && !desc_wr_data[1]));

  assert_mem_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

  assert_byte_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  assert_evt_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_txb, evt_txe}));

  assert_evt_with_wb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_txb || evt_txe) |-> desc_wr_en);

  assert_wb_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    desc_wr_en |-> (desc_wr_addr == $past(desc_rd_addr)));

  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (desc_wr_en && desc_wr_data[14] && ($past(cfg_mask_txb) || $past(cfg_mask_txe))));

  assert_idx_even_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !desc_rd_addr[0]);
endmodule

bind txdesc_engine txdesc_engine_chk #(.RING_WORDS(RING_WORDS)) u_chk (.*);

// File: tb/txdesc_engine_test.sv
`timescale 1ns/1ps
module txdesc_engine_test;
  localparam int RW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_tx_en = 0, cfg_pad_all = 0, cfg_huge = 0, cfg_crc_all = 0;
  logic [15:0] cfg_min_len = 16'd60, cfg_max_len = 16'd1536;
  logic cfg_mask_txb = 0, cfg_mask_txe = 0;
  logic [3:0]  desc_rd_addr, desc_wr_addr;
  logic [31:0] desc_stat_rdata, desc_ptr_rdata, desc_wr_data;
  logic desc_wr_en, mem_req, mem_rvalid = 0, tx_valid, tx_last, tx_ready = 1;
  logic [31:0] mem_addr, mem_rdata = 0;
  logic [7:0]  tx_data;
  logic [15:0] tx_min_len, tx_max_len;
  logic tx_add_crc, tx_done = 0, tx_ok = 0, evt_txb, evt_txe, irq;

  logic [31:0] ram [RW];
  int checks = 0, fails = 0;
  int ncap = 0, nreads = 0, wb_seen = 0;
  logic [7:0] cap_byte [256];
  logic       cap_last [256];
  logic [31:0] wb_data;
  logic [3:0]  wb_addr, wb_next;
  logic wb_txb, wb_txe, wb_irq;
  logic stall = 0, tog = 0, finished = 0;
  logic [3:0] exp_idx = 0;

  always #4 clk = ~clk;

  assign desc_stat_rdata = ram[desc_rd_addr];
  assign desc_ptr_rdata  = ram[4'(desc_rd_addr + 4'd1)];

  txdesc_engine #(.RING_WORDS(RW), .AW(32)) uut (.*);

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {a[7:0] + 8'h11, a[7:0] ^ 8'h5A, a[15:8], ~a[7:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // environment: memory responder, stream sink, write-back monitor
  initial begin
    forever begin
      @(negedge clk);
      tog = ~tog;
      tx_ready = stall ? tog : 1'b1;
      mem_rvalid = mem_req && !mem_rvalid;
      mem_rdata = memf(mem_addr);
      #1;
      if (tx_valid && tx_ready) begin
        cap_byte[ncap[7:0]] = tx_data;
        cap_last[ncap[7:0]] = tx_last;
        ncap++;
      end
      if (mem_req && mem_rvalid) nreads++;
      if (desc_wr_en) begin
        wb_seen++;
        wb_addr = desc_wr_addr; wb_data = desc_wr_data;
        wb_txb = evt_txb; wb_txe = evt_txe; wb_irq = irq; wb_next = desc_rd_addr;
        ram[desc_wr_addr] = desc_wr_data;
      end
    end
  end

  task automatic run_frame(input logic [31:0] stat, input logic [31:0] ptr, input logic ok,
                           input logic [15:0] emin, input logic [15:0] emax,
                           input logic ecrc, input logic eirq);
    int L;
    logic [4:0] nx;
    logic [31:0] w;
    cfg_tx_en = 0;
    repeat (3) @(negedge clk);
    ram[exp_idx] = stat;
    ram[4'(exp_idx + 4'd1)] = ptr;
    ncap = 0; nreads = 0; wb_seen = 0;
    cfg_tx_en = 1;
    L = int'(stat[31:16]);
    for (int i = 0; i < 3000 && ncap < L; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R9 no write-back before done", wb_seen, 0);
    tx_done = 1; tx_ok = ok;
    @(negedge clk);
    tx_done = 0;
    chk("R9 write-back one cycle after done", desc_wr_en, 1);
    #2;
    chk("R9 single write-back", wb_seen, 1);
    chk("R9 write-back index", wb_addr, exp_idx);
    chk("R9 success event", wb_txb, ok);
    chk("R9 error event", wb_txe, !ok);
    chk("R3 written status", wb_data, stat & ~32'h0000_83FE);
    chk("R10 irq", wb_irq, eirq);
    nx = {1'b0, exp_idx} + 5'd2;
    exp_idx = (stat[13] || nx >= 5'(RW)) ? 4'd0 : nx[3:0];
    chk("R11 next index", wb_next, exp_idx);
    chk("R4 min length", tx_min_len, emin);
    chk("R5 max length", tx_max_len, emax);
    chk("R6 crc append", tx_add_crc, ecrc);
    chk("R7 read count", nreads, (L + 3) / 4);
    chk("R8 byte count", ncap, L);
    for (int k = 0; k < L; k++) begin
      w = memf(ptr + 32'(4 * (k / 4)));
      chk("R8 byte value", cap_byte[k], (w >> (24 - 8 * (k % 4))) & 32'hFF);
      chk("R8 last flag", cap_last[k], (k == L - 1));
    end
    @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 wr_en", desc_wr_en, 0);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 events", {evt_txb, evt_txe, irq}, 0);
    chk("R1 index", desc_rd_addr, 0);
  endtask

  task automatic t_basic;
    cfg_mask_txb = 1;
    run_frame({16'd10, 16'hC3FF}, 32'h100, 1, 16'd10, 16'd1536, 0, 1);
  endtask

  task automatic t_pad_huge_crc;
    cfg_mask_txb = 1; cfg_huge = 1; stall = 1;
    run_frame({16'd7, 16'h9C00}, 32'h2000, 0, 16'd60, 16'd7, 1, 0);
    cfg_huge = 0; stall = 0;
  endtask

  task automatic t_globals_pad;
    cfg_pad_all = 1; cfg_mask_txb = 0; cfg_mask_txe = 0;
    run_frame({16'd4, 16'hC800}, 32'h340, 1, 16'd60, 16'd1536, 0, 0);
    cfg_pad_all = 0;
  endtask

  task automatic t_not_ready;
    cfg_tx_en = 0;
    repeat (3) @(negedge clk);
    ram[exp_idx] = {16'd5, 16'h4000};
    ram[4'(exp_idx + 4'd1)] = 32'h500;
    nreads = 0; wb_seen = 0; ncap = 0;
    cfg_tx_en = 1;
    repeat (20) @(negedge clk);
    chk("R2 no read while not ready", nreads, 0);
    chk("R2 no write-back while not ready", wb_seen, 0);
    chk("R2 index held", desc_rd_addr, exp_idx);
    cfg_crc_all = 1; cfg_mask_txe = 1;
    run_frame({16'd5, 16'hC000}, 32'h500, 1, 16'd5, 16'd1536, 1, 1);
    cfg_crc_all = 0; cfg_mask_txe = 0;
  endtask

  task automatic t_disabled;
    cfg_tx_en = 0;
    repeat (3) @(negedge clk);
    ram[exp_idx] = {16'd3, 16'h8000};
    ram[4'(exp_idx + 4'd1)] = 32'h600;
    nreads = 0; wb_seen = 0; ncap = 0;
    repeat (20) @(negedge clk);
    chk("R2 no read while disabled", nreads, 0);
    chk("R2 no bytes while disabled", ncap, 0);
    stall = 1;
    run_frame({16'd3, 16'h8000}, 32'h600, 1, 16'd3, 16'd1536, 0, 0);
    stall = 0;
  endtask

  task automatic t_zero_len;
    cfg_mask_txb = 1;
    run_frame({16'd0, 16'hC001}, 32'h700, 1, 16'd0, 16'd1536, 0, 1);
  endtask

  task automatic t_wrap;
    run_frame({16'd2, 16'hA000}, 32'h800, 1, 16'd2, 16'd1536, 0, 0);
    chk("R11 wrap flag returns to 0", exp_idx, 0);
  endtask

  task automatic t_ring_end;
    for (int d = 0; d < RW / 2; d++)
      run_frame({16'd1, 16'h8000}, 32'h900 + 32'(16 * d), 1, 16'd1, 16'd1536, 0, 0);
    chk("R11 ring end returns to 0", desc_rd_addr, 0);
  endtask

  initial begin
    for (int i = 0; i < RW; i++) ram[i] = '0;
    t_reset();
    t_basic();
    t_pad_huge_crc();
    t_globals_pad();
    t_not_ready();
    t_disabled();
    t_zero_len();
    t_wrap();
    t_ring_end();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog R9 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule